// File: doc/BRIEF.md
# Processor-to-Host Message Channel

This block sits between a small processor core and an external test host. The host releases the core by issuing a start command that carries a program address. The block loads that address into the core's program-counter load value and raises a run signal. While the core runs, every write it makes to a dedicated to-host register is split into a 2-bit message kind and a 16-bit payload. The message is then queued toward the host over a valid/ready handshake. When the queue is full, a busy signal stalls the core, so that no message is dropped.

A host-side monitor is included with the channel. It reads each message as it leaves the queue and reports one of four outcomes: a printed character, a reassembled 32-bit integer (a low-half message followed by a high-half message), a protocol error, or the end of the run with a pass or fail verdict. An exit message stops the core. Any register writes after that point are discarded until the host issues the next start command.

Top module: `host_msg_link`

## Requirements
- R1: After reset, run is low, the program-counter load value is 0, no message is offered (msg_valid low), busy is low and every monitor output is low.
- R2: A start command (start_valid high at a clock edge) makes run high and pc_load equal to start_addr after that edge. pc_load holds its value at every other edge.
- R3: A register write is ignored while run is low. This includes writes before the first start and writes after an exit: nothing is queued and the monitor reports nothing.
- R4: An accepted write takes its message kind from bits [17:16] and its payload from bits [15:0]. Bits [31:18] have no effect. Kind encodings: 0 exit, 1 print character, 2 integer low half, 3 integer high half.
- R5: The queue holds DEPTH messages (default 4) and delivers them in write order. busy is high exactly while the queue is full. A write presented while busy is high is not taken and must be held by the core. An offered message and its payload stay stable until msg_ready takes it.
- R6: An accepted exit write (kind 0) drives run low after that edge.
- R7: If a start command and an accepted exit write fall on the same edge, the exit message is still queued, run stays high, and pc_load takes the new start address.
- R8: When a kind-1 message is taken, the monitor pulses mon_char_valid for one cycle, with mon_char equal to payload bits [7:0].
- R9: When a kind-3 message is taken and a kind-2 message came before it with no kind-3 in between, the monitor pulses mon_int_valid for one cycle, with mon_int = {high payload, low payload}. A second kind-2 message replaces the pending low half.
- R10: When a kind-3 message is taken with no pending low half, the monitor pulses mon_proto_err for one cycle and does not pulse mon_int_valid.
- R11: When a kind-0 message is taken, the monitor sets mon_done. It sets mon_pass to 1 if the payload is zero and to 0 otherwise. Both stay set until the next start command clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Host start command |
| start_addr | input | 32 | Address at which the core begins |
| run | output | 1 | Core may execute |
| pc_load | output | 32 | Program-counter load value |
| csr_wr | input | 1 | Core writes the to-host register |
| csr_wdata | input | 32 | Value written |
| core_busy | output | 1 | Queue full; core must hold its write |
| msg_valid | output | 1 | Message offered to host |
| msg_ready | input | 1 | Host takes the offered message |
| msg_kind | output | 2 | Kind of offered message |
| msg_data | output | 16 | Payload of offered message |
| mon_char_valid | output | 1 | Character printed (one-cycle pulse) |
| mon_char | output | 8 | Printed character |
| mon_int_valid | output | 1 | Integer completed (one-cycle pulse) |
| mon_int | output | 32 | Reassembled integer |
| mon_proto_err | output | 1 | High half without low half (one-cycle pulse) |
| mon_done | output | 1 | Exit received |
| mon_pass | output | 1 | Exit payload was zero |

## Verification
Two pairs of events can land on the same edge. The first pair is a start command and an exit write. The bench drives both on one edge, then checks that run stays high, that pc_load holds the new address, and that the monitor still reports the exit one cycle later. The second pair is a queue pop and a blocked write. The bench fills the queue with the host stalled, then releases msg_ready while a fifth write is pending. It checks that the write waits one edge and that all five characters reach the monitor in order.

// File: rtl/host_msg_pkg.sv
package host_msg_pkg;

  typedef enum logic [1:0] {
    KIND_EXIT   = 2'd0,
    KIND_CHAR   = 2'd1,
    KIND_INT_LO = 2'd2,
    KIND_INT_HI = 2'd3
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e   kind;
    logic [15:0] payload;
  } host_msg_t;

  localparam int MSG_BITS = $bits(host_msg_t);

endpackage

// File: rtl/msg_queue.sv
module msg_queue #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             not_empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data = store[rd_ptr];
  assign not_empty = (count != '0);
  assign full      = (count == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> not_empty); // R5
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
    (not_empty && !pop) |=> (not_empty && $stable(head_data))); // R5

endmodule

// File: rtl/run_gate.sv
module run_gate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_valid,
  input  logic [AW-1:0] start_addr,
  input  logic          exit_taken,
  output logic          run,
  output logic [AW-1:0] pc_load
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      pc_load <= '0;
    end else if (start_valid) begin
      run     <= 1'b1;
      pc_load <= start_addr;
    end else if (exit_taken) begin
      run     <= 1'b0;
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(start_valid)) |-> (run && pc_load == $past(start_addr))); // R2
  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!run && !start_valid) |=> !run); // R3
  AST_EXIT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (exit_taken && !start_valid) |=> !run); // R6

endmodule

// File: rtl/msg_monitor.sv
module msg_monitor
  import host_msg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        take,
  input  host_msg_t   msg,
  output logic        char_valid,
  output logic [7:0]  char_out,
  output logic        int_valid,
  output logic [31:0] int_out,
  output logic        proto_err,
  output logic        done,
  output logic        pass
);
  logic        low_pending;
  logic [15:0] low_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      char_valid  <= 1'b0;
      char_out    <= '0;
      int_valid   <= 1'b0;
      int_out     <= '0;
      proto_err   <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      low_pending <= 1'b0;
      low_half    <= '0;
    end else begin
      char_valid <= 1'b0;
      int_valid  <= 1'b0;
      proto_err  <= 1'b0;
      if (clear) begin
        done        <= 1'b0;
        pass        <= 1'b0;
        low_pending <= 1'b0;
      end
      if (take) begin
        unique case (msg.kind)
          KIND_CHAR: begin
            char_valid <= 1'b1;
            char_out   <= msg.payload[7:0];
          end
          KIND_INT_LO: begin
            low_half    <= msg.payload;
            low_pending <= 1'b1;
          end
          KIND_INT_HI: begin
            if (low_pending) begin
              int_valid   <= 1'b1;
              int_out     <= {msg.payload, low_half};
              low_pending <= 1'b0;
            end else begin
              proto_err <= 1'b1;
            end
          end
          KIND_EXIT: begin
            done <= 1'b1;
            pass <= (msg.payload == 16'd0);
          end
        endcase
      end
    end
  end

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> !int_valid); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !clear) |=> done); // R11

endmodule

// File: rtl/host_msg_link.sv
module host_msg_link
  import host_msg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              run,
  output logic [ADDR_W-1:0] pc_load,
  input  logic              csr_wr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic              core_busy,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_kind,
  output logic [15:0]       msg_data,
  output logic              mon_char_valid,
  output logic [7:0]        mon_char,
  output logic              mon_int_valid,
  output logic [31:0]       mon_int,
  output logic              mon_proto_err,
  output logic              mon_done,
  output logic              mon_pass
);
  host_msg_t          in_msg, head_msg;
  logic [MSG_BITS-1:0] head_bits;
  logic               q_full, q_nonempty, accept, deliver;

  assign in_msg.kind    = msg_kind_e'(csr_wdata[17:16]);
  assign in_msg.payload = csr_wdata[15:0];

  assign accept  = csr_wr && run && !q_full;
  assign deliver = q_nonempty && msg_ready;

  msg_queue #(.WIDTH(MSG_BITS), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (accept),
    .push_data (in_msg),
    .pop       (deliver),
    .head_data (head_bits),
    .not_empty (q_nonempty),
    .full      (q_full)
  );

  assign head_msg  = host_msg_t'(head_bits);
  assign msg_valid = q_nonempty;
  assign msg_kind  = head_msg.kind;
  assign msg_data  = head_msg.payload;
  assign core_busy = q_full;

  run_gate #(.AW(ADDR_W)) u_run (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_addr  (start_addr),
    .exit_taken  (accept && in_msg.kind == KIND_EXIT),
    .run         (run),
    .pc_load     (pc_load)
  );

  msg_monitor u_mon (
    .clk        (clk),
    .rst        (rst),
    .clear      (start_valid),
    .take       (deliver),
    .msg        (head_msg),
    .char_valid (mon_char_valid),
    .char_out   (mon_char),
    .int_valid  (mon_int_valid),
    .int_out    (mon_int),
    .proto_err  (mon_proto_err),
    .done       (mon_done),
    .pass       (mon_pass)
  );

  AST_HALTED_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    (!run && !msg_valid) |=> !msg_valid); // R3

endmodule

// File: tb/test_host_msg_link.sv
`timescale 1ns/1ps
module test_host_msg_link;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_valid;
  logic [31:0] start_addr;
  logic        run;
  logic [31:0] pc_load;
  logic        csr_wr;
  logic [31:0] csr_wdata;
  logic        core_busy, msg_valid, msg_ready;
  logic [1:0]  msg_kind;
  logic [15:0] msg_data;
  logic        mon_char_valid, mon_int_valid, mon_proto_err, mon_done, mon_pass;
  logic [7:0]  mon_char;
  logic [31:0] mon_int;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  char_log [0:511];
  logic [31:0] int_log  [0:127];
  int n_char = 0;
  int n_int  = 0;
  int n_err  = 0;

  always #2 clk = ~clk;

  host_msg_link i_host_msg_link (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_addr(start_addr),
    .run(run), .pc_load(pc_load), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .core_busy(core_busy), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_kind(msg_kind), .msg_data(msg_data),
    .mon_char_valid(mon_char_valid), .mon_char(mon_char),
    .mon_int_valid(mon_int_valid), .mon_int(mon_int),
    .mon_proto_err(mon_proto_err), .mon_done(mon_done), .mon_pass(mon_pass));

  always @(negedge clk) begin
    if (mon_char_valid) begin
      if (n_char < 512) char_log[n_char] = mon_char;
      n_char++;
    end
    if (mon_int_valid) begin
      if (n_int < 128) int_log[n_int] = mon_int;
      n_int++;
    end
    if (mon_proto_err) n_err++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    csr_wr = 1'b1;
    csr_wdata = v;
    while (core_busy) @(negedge clk);
    @(posedge clk);
    #1;
    csr_wr = 1'b0;
  endtask

  task automatic start(input logic [31:0] a);
    @(negedge clk);
    start_valid = 1'b1;
    start_addr = a;
    @(posedge clk);
    #1;
    start_valid = 1'b0;
    check("R2 run", run, 1);
    check("R2 pc_load", pc_load, a);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  function automatic logic [13:0] junk(input int i);
    return 14'(i * 977 + 5);
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    rst = 1'b1; start_valid = 0; start_addr = 0; csr_wr = 0; csr_wdata = 0; msg_ready = 1;
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 run", run, 0);
    check("R1 pc_load", pc_load, 0);
    check("R1 msg_valid", msg_valid, 0);
    check("R1 busy", core_busy, 0);
    check("R1 monitor", {mon_char_valid, mon_int_valid, mon_proto_err, mon_done, mon_pass}, 0);

    // R3: write before start is ignored
    wr({14'h3fff, 2'b01, 16'h0041});
    check("R3 pre-start msg_valid", msg_valid, 0);
    idle(3);
    check("R3 pre-start no char", n_char, 0);
    check("R2 pc held", pc_load, 0);

    start(32'h0000_0200);

    // R4 R8: sweep all character codes with junk upper bits
    for (int c = 0; c < 256; c++)
      wr({junk(c), 2'b01, 8'(c * 37 + 11), 8'(c)});
    idle(4);
    check("R8 char count", n_char, 256);
    for (int c = 0; c < 256; c++)
      check("R8 R4 char value", char_log[c], 32'(c));

    // R9: integers as low then high halves
    for (int i = 0; i < 64; i++) begin
      logic [31:0] v;
      v = 32'(i) * 32'h0409_1D37 ^ (32'(i) << 27);
      wr({junk(i + 3), 2'b10, v[15:0]});
      wr({junk(i + 7), 2'b11, v[31:16]});
    end
    idle(4);
    check("R9 int count", n_int, 64);
    for (int i = 0; i < 64; i++)
      check("R9 int value", int_log[i], 32'(i) * 32'h0409_1D37 ^ (32'(i) << 27));

    // R9: second low half replaces the first
    wr({14'd0, 2'b10, 16'hAAAA});
    wr({14'd0, 2'b10, 16'h1234});
    wr({14'd0, 2'b11, 16'hBEEF});
    idle(4);
    check("R9 low replaced", int_log[64], 32'hBEEF_1234);

    // R10: high half without low half
    wr({14'd5, 2'b11, 16'h7777});
    idle(4);
    check("R10 proto err", n_err, 1);
    check("R10 no int", n_int, 65);

    // R5: fill queue with host stalled, then pop and a held write together
    msg_ready = 1'b0;
    base = n_char;
    for (int i = 0; i < 4; i++) wr({14'd0, 2'b01, 8'd0, 8'(8'h61 + i)});
    #1;
    check("R5 busy when full", core_busy, 1);
    check("R5 head held", {msg_kind, msg_data}, {2'b01, 16'h0061});
    fork
      wr({14'd0, 2'b01, 16'h0065});
      begin @(negedge clk); msg_ready = 1'b1; end
    join
    idle(8);
    check("R5 count", n_char - base, 5);
    for (int i = 0; i < 5; i++)
      check("R5 order", char_log[base + i], 32'(8'h61 + i));
    check("R5 busy cleared", core_busy, 0);

    // R6 R11: exit pass
    wr({14'h2aaa, 2'b00, 16'h0000});
    check("R6 run low", run, 0);
    idle(1);
    check("R11 done", mon_done, 1);
    check("R11 pass", mon_pass, 1);
    base = n_char;
    wr({14'd0, 2'b01, 16'h0042});
    check("R3 after exit msg_valid", msg_valid, 0);
    idle(3);
    check("R3 after exit no char", n_char, base);
    check("R11 done sticky", mon_done, 1);

    // R11: exit fail, cleared by start
    start(32'h0000_0400);
    check("R11 cleared by start", {mon_done, mon_pass}, 0);
    wr({14'd0, 2'b00, 16'h0005});
    idle(1);
    check("R11 fail done", mon_done, 1);
    check("R11 fail pass", mon_pass, 0);

    // R7: start and exit on the same edge
    start(32'h0000_0600);
    @(negedge clk);
    start_valid = 1'b1; start_addr = 32'h0000_0800;
    csr_wr = 1'b1; csr_wdata = {14'd0, 2'b00, 16'h0000};
    @(posedge clk); #1;
    start_valid = 1'b0; csr_wr = 1'b0;
    check("R7 run stays high", run, 1);
    check("R7 pc reloaded", pc_load, 32'h0000_0800);
    idle(1);
    check("R7 exit still queued", mon_done, 1);
    check("R7 exit pass", mon_pass, 1);
    base = n_char;
    wr({14'd0, 2'b01, 16'h0043});
    idle(3);
    check("R7 still accepting", n_char, base + 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule